// File: doc/BRIEF.md
# Thermal Sensor Register Bank

This block holds the programmable registers of a temperature sensor. They are 16 bits wide and a byte-wide host port reaches them through an 8-bit pointer. A host first writes the pointer. It then moves whole 16-bit words through two byte transfers, high byte first. The bank holds a fixed capability word, a configuration word, three temperature limits (upper alarm, lower alarm, critical) and a read-only sample word. The sample word carries the live temperature and three comparison flags, which the block takes in from the event logic.

The configuration fields and the limits go straight out to the event logic. Two lock bits in the configuration word freeze the limit registers and the event mode and polarity fields. The block also compares a 7-bit bus address with its own address. That address is a fixed 4-bit prefix followed by three strap pins.

Top module: `tsens_regbank`

## Requirements
- R1: After reset the bank reads capability 0x0001; configuration, upper, lower, critical and sample all read 0x0000.
- R2: Pointer bits 2:0 select 000 capability, 001 configuration, 010 upper, 011 lower, 100 critical, 101 sample. A pointer with any of bits 7:3 set, or a select of 110/111, reads 0x0000 and its writes change nothing.
- R3: Words move high byte first. A write changes a register only on its second data byte. A pointer write restarts both byte sequences. The whole word is captured on the high-byte read, and `host_rdata` shows each byte in the cycle after its read strobe.
- R4: The capability word is read-only and always reads 0x0001.
- R5: A limit register stores written bits 12:2, reads bits 15:13 and 1:0 as zero, and exports the stored 11 bits.
- R6: A `temp_valid` strobe loads the sample word as {over-critical in bit 15, over-window in bit 14, under-window in bit 13, temperature in bits 12:0}. Host writes to it are ignored.
- R7: While configuration bit 6 (alarm lock) is set, writes to the upper and lower limits are ignored.
- R8: While configuration bit 7 (critical lock) is set, writes to the critical limit are ignored.
- R9: While bit 6 or bit 7 holds 1 before a configuration write, that write leaves bit 0 (event mode, 1 = interrupt) and bit 1 (polarity, 1 = active high) unchanged and updates the other writable fields. Those fields are bit 2 critical-only, bit 3 output enable, bits 7:6 locks, bit 8 shutdown, and bits 10:9 hysteresis.
- R10: Configuration bit 4 reads the `evt_status` input and ignores writes; bits 15:11 read zero.
- R11: Writing 1 to configuration bit 5 raises `clr_event` for exactly the one cycle after the write completes; bit 5 always reads 0.
- R12: `addr_hit` is high exactly when `bus_addr` equals binary 0011 followed by `strap[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ptr_we | input | 1 | Load pointer from `host_wdata` |
| host_wr | input | 1 | Data byte write strobe |
| host_rd | input | 1 | Data byte read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| temp_valid | input | 1 | New sample strobe |
| temp_value | input | 13 | Sampled temperature |
| temp_over_crit | input | 1 | Sample above critical limit |
| temp_over_win | input | 1 | Sample above alarm window |
| temp_under_win | input | 1 | Sample below alarm window |
| evt_status | input | 1 | Event output currently asserted |
| strap | input | 3 | Address strap pins |
| bus_addr | input | 7 | Address seen on the serial bus |
| addr_hit | output | 1 | Bus address matches this device |
| cfg_event_mode | output | 1 | 1 = interrupt mode, 0 = comparator |
| cfg_active_high | output | 1 | Event output polarity |
| cfg_crit_only | output | 1 | Event only on critical |
| cfg_evt_enable | output | 1 | Event output enable |
| cfg_shutdown | output | 1 | Sensor shutdown |
| cfg_hyst | output | 2 | Hysteresis select |
| clr_event | output | 1 | One-cycle event clear pulse |
| lim_upper | output | 11 | Upper alarm limit |
| lim_lower | output | 11 | Lower alarm limit |
| lim_crit | output | 11 | Critical limit |

## Verification
The bench writes all-ones into every register, which separates the writable bits from the reserved and read-only bits. It writes sparse patterns into the limits and the configuration word, with and without each lock set, which separates frozen fields from free ones. It changes the sample between the two byte reads of one word, which shows whether the low byte comes from the captured word or from the live register. Writes cut off after one byte and out-of-range pointers show that incomplete or misaddressed transfers leave every register unchanged.

// File: rtl/tsens_pkg.sv
package tsens_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int SEL_W   = 3;
  localparam int TEMP_W  = 13;
  localparam int LIM_LSB = 2;
  localparam int LIM_W   = 11;
  localparam int NLIM    = 3;
  localparam int STRAP_W = 3;
  localparam int ADDR_W  = 7;

  // limit slot order inside the limit vector
  localparam int LIM_HI   = 0;
  localparam int LIM_LO   = 1;
  localparam int LIM_CRIT = 2;

  // configuration word bit positions
  localparam int CFG_MODE   = 0;
  localparam int CFG_POL    = 1;
  localparam int CFG_CONLY  = 2;
  localparam int CFG_OEN    = 3;
  localparam int CFG_STAT   = 4;
  localparam int CFG_CLR    = 5;
  localparam int CFG_ALOCK  = 6;
  localparam int CFG_CLOCK  = 7;
  localparam int CFG_SHDN   = 8;
  localparam int CFG_HYST   = 9;

  typedef enum logic [SEL_W-1:0] {
    SEL_CAP  = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_HI   = 3'd2,
    SEL_LO   = 3'd3,
    SEL_CRIT = 3'd4,
    SEL_TEMP = 3'd5
  } sel_e;

  typedef struct packed {
    logic [1:0] hyst;
    logic       shutdown;
    logic       crit_lock;
    logic       alarm_lock;
    logic       out_en;
    logic       crit_only;
    logic       polarity;
    logic       event_mode;
  } cfg_t;
endpackage

// File: rtl/tsens_host_seq.sv
module tsens_host_seq
  import tsens_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic          wr_byte,
  input  logic          rd_byte,
  input  logic [BW-1:0] wdata,
  input  logic [WW-1:0] rd_word,
  output logic [BW-1:0] ptr_q,
  output logic          commit,
  output logic [WW-1:0] commit_word,
  output logic [BW-1:0] rdata
);
  logic [BW-1:0] ptr_d, hold_q, hold_d, shadow_q, shadow_d, rdata_q, rdata_d;
  logic          wr_phase_q, wr_phase_d, rd_phase_q, rd_phase_d;

  always_comb begin
    ptr_d      = ptr_q;
    hold_d     = hold_q;
    shadow_d   = shadow_q;
    rdata_d    = rdata_q;
    wr_phase_d = wr_phase_q;
    rd_phase_d = rd_phase_q;
    if (ptr_we) begin
      ptr_d      = wdata;
      wr_phase_d = 1'b0;
      rd_phase_d = 1'b0;
    end else begin
      if (wr_byte) begin
        if (!wr_phase_q) begin
          hold_d     = wdata;
          wr_phase_d = 1'b1;
        end else begin
          wr_phase_d = 1'b0;
        end
      end
      if (rd_byte) begin
        if (!rd_phase_q) begin
          rdata_d    = rd_word[WW-1:BW];
          shadow_d   = rd_word[BW-1:0];
          rd_phase_d = 1'b1;
        end else begin
          rdata_d    = shadow_q;
          rd_phase_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      hold_q     <= '0;
      shadow_q   <= '0;
      rdata_q    <= '0;
      wr_phase_q <= 1'b0;
      rd_phase_q <= 1'b0;
    end else begin
      ptr_q      <= ptr_d;
      hold_q     <= hold_d;
      shadow_q   <= shadow_d;
      rdata_q    <= rdata_d;
      wr_phase_q <= wr_phase_d;
      rd_phase_q <= rd_phase_d;
    end
  end

  assign commit      = !ptr_we && wr_byte && wr_phase_q;
  assign commit_word = {hold_q, wdata};
  assign rdata       = rdata_q;

  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (!wr_phase_q && !rd_phase_q)); // R3
endmodule

// File: rtl/tsens_ctrl_regs.sv
module tsens_ctrl_regs
  import tsens_pkg::*;
#(
  parameter int LW = LIM_W,
  parameter int LSB = LIM_LSB,
  parameter int NL = NLIM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic [NL-1:0]     wr_lim,
  input  logic [WORD_W-1:0] wword,
  output cfg_t              cfg_q,
  output logic [NL*LW-1:0]  lim_q,
  output logic              clr_pulse
);
  cfg_t       cfg_d;
  logic       clr_d;
  logic       locked;
  logic [NL-1:0] lim_lock;
  logic       unused_top_bits;

  assign locked          = cfg_q.alarm_lock | cfg_q.crit_lock;
  assign unused_top_bits = ^wword[WORD_W-1:LSB+LW];

  always_comb begin
    cfg_d = cfg_q;
    clr_d = 1'b0;
    if (wr_cfg) begin
      cfg_d.hyst       = wword[CFG_HYST +: 2];
      cfg_d.shutdown   = wword[CFG_SHDN];
      cfg_d.crit_lock  = wword[CFG_CLOCK];
      cfg_d.alarm_lock = wword[CFG_ALOCK];
      cfg_d.out_en     = wword[CFG_OEN];
      cfg_d.crit_only  = wword[CFG_CONLY];
      clr_d            = wword[CFG_CLR];
      if (!locked) begin
        cfg_d.polarity   = wword[CFG_POL];
        cfg_d.event_mode = wword[CFG_MODE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      clr_pulse <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      clr_pulse <= clr_d;
    end
  end

  always_comb begin
    lim_lock           = '0;
    lim_lock[LIM_HI]   = cfg_q.alarm_lock;
    lim_lock[LIM_LO]   = cfg_q.alarm_lock;
    lim_lock[LIM_CRIT] = cfg_q.crit_lock;
  end

  for (genvar i = 0; i < NL; i++) begin : g_lim
    logic [LW-1:0] q, d;
    always_comb begin
      d = q;
      if (wr_lim[i] && !lim_lock[i]) d = wword[LSB +: LW];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign lim_q[i*LW +: LW] = q;
  end

  AST_ALARM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_lim[LIM_HI] || wr_lim[LIM_LO]) && cfg_q.alarm_lock)
      |=> ($stable(lim_q[LIM_HI*LW +: LW]) && $stable(lim_q[LIM_LO*LW +: LW]))); // R7
  AST_CRIT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lim[LIM_CRIT] && cfg_q.crit_lock) |=> $stable(lim_q[LIM_CRIT*LW +: LW])); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && (cfg_q.alarm_lock || cfg_q.crit_lock))
      |=> ($stable(cfg_q.polarity) && $stable(cfg_q.event_mode))); // R9
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse); // R11
endmodule

// File: rtl/tsens_addr_dec.sv
module tsens_addr_dec
  import tsens_pkg::*;
#(
  parameter int SW = STRAP_W,
  parameter int AW = ADDR_W,
  parameter logic [AW-SW-1:0] PREFIX = 4'b0011
) (
  input  logic [SW-1:0] strap,
  input  logic [AW-1:0] bus_addr,
  output logic          hit
);
  logic [AW-1:0] own_addr;
  assign own_addr = {PREFIX, strap};
  assign hit      = (bus_addr == own_addr);
endmodule

// File: rtl/tsens_regbank.sv
module tsens_regbank
  import tsens_pkg::*;
#(
  parameter logic [3:0]        ADDR_PREFIX = 4'b0011,
  parameter logic [WORD_W-1:0] CAP_VALUE   = 16'h0001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_ptr_we,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [BYTE_W-1:0]  host_wdata,
  output logic [BYTE_W-1:0]  host_rdata,
  input  logic               temp_valid,
  input  logic [TEMP_W-1:0]  temp_value,
  input  logic               temp_over_crit,
  input  logic               temp_over_win,
  input  logic               temp_under_win,
  input  logic               evt_status,
  input  logic [STRAP_W-1:0] strap,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               addr_hit,
  output logic               cfg_event_mode,
  output logic               cfg_active_high,
  output logic               cfg_crit_only,
  output logic               cfg_evt_enable,
  output logic               cfg_shutdown,
  output logic [1:0]         cfg_hyst,
  output logic               clr_event,
  output logic [LIM_W-1:0]   lim_upper,
  output logic [LIM_W-1:0]   lim_lower,
  output logic [LIM_W-1:0]   lim_crit
);
  localparam int PAD_HI = WORD_W - LIM_W - LIM_LSB;

  logic [BYTE_W-1:0]   ptr_q;
  logic                commit;
  logic [WORD_W-1:0]   commit_word, rd_word, cfg_rd;
  logic                ptr_ok;
  logic [SEL_W-1:0]    sel;
  logic                wr_cfg;
  logic [NLIM-1:0]     wr_lim;
  cfg_t                cfg_q;
  logic [NLIM*LIM_W-1:0] lim_q;
  logic [WORD_W-1:0]   temp_q, temp_d;

  tsens_host_seq #(.BW(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ptr_we(host_ptr_we), .wr_byte(host_wr),
    .rd_byte(host_rd), .wdata(host_wdata), .rd_word(rd_word), .ptr_q(ptr_q),
    .commit(commit), .commit_word(commit_word), .rdata(host_rdata)
  );

  assign ptr_ok = (ptr_q[BYTE_W-1:SEL_W] == '0);
  assign sel    = ptr_q[SEL_W-1:0];

  always_comb begin
    wr_cfg           = commit && ptr_ok && (sel == SEL_CFG);
    wr_lim           = '0;
    wr_lim[LIM_HI]   = commit && ptr_ok && (sel == SEL_HI);
    wr_lim[LIM_LO]   = commit && ptr_ok && (sel == SEL_LO);
    wr_lim[LIM_CRIT] = commit && ptr_ok && (sel == SEL_CRIT);
  end

  tsens_ctrl_regs #(.LW(LIM_W), .LSB(LIM_LSB), .NL(NLIM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_lim(wr_lim),
    .wword(commit_word), .cfg_q(cfg_q), .lim_q(lim_q), .clr_pulse(clr_event)
  );

  tsens_addr_dec #(.SW(STRAP_W), .AW(ADDR_W), .PREFIX(ADDR_PREFIX)) u_addr (
    .strap(strap), .bus_addr(bus_addr), .hit(addr_hit)
  );

  // sample word: flags above the temperature field
  always_comb begin
    temp_d = temp_q;
    if (temp_valid) temp_d = {temp_over_crit, temp_over_win, temp_under_win, temp_value};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) temp_q <= '0;
    else        temp_q <= temp_d;
  end

  always_comb begin
    cfg_rd               = '0;
    cfg_rd[CFG_MODE]     = cfg_q.event_mode;
    cfg_rd[CFG_POL]      = cfg_q.polarity;
    cfg_rd[CFG_CONLY]    = cfg_q.crit_only;
    cfg_rd[CFG_OEN]      = cfg_q.out_en;
    cfg_rd[CFG_STAT]     = evt_status;
    cfg_rd[CFG_ALOCK]    = cfg_q.alarm_lock;
    cfg_rd[CFG_CLOCK]    = cfg_q.crit_lock;
    cfg_rd[CFG_SHDN]     = cfg_q.shutdown;
    cfg_rd[CFG_HYST +: 2] = cfg_q.hyst;
  end

  always_comb begin
    rd_word = '0;
    if (ptr_ok) begin
      case (sel)
        SEL_CAP:  rd_word = CAP_VALUE;
        SEL_CFG:  rd_word = cfg_rd;
        SEL_HI:   rd_word = {{PAD_HI{1'b0}}, lim_q[LIM_HI*LIM_W +: LIM_W], {LIM_LSB{1'b0}}};
        SEL_LO:   rd_word = {{PAD_HI{1'b0}}, lim_q[LIM_LO*LIM_W +: LIM_W], {LIM_LSB{1'b0}}};
        SEL_CRIT: rd_word = {{PAD_HI{1'b0}}, lim_q[LIM_CRIT*LIM_W +: LIM_W], {LIM_LSB{1'b0}}};
        SEL_TEMP: rd_word = temp_q;
        default:  rd_word = '0;
      endcase
    end
  end

  assign cfg_event_mode  = cfg_q.event_mode;
  assign cfg_active_high = cfg_q.polarity;
  assign cfg_crit_only   = cfg_q.crit_only;
  assign cfg_evt_enable  = cfg_q.out_en;
  assign cfg_shutdown    = cfg_q.shutdown;
  assign cfg_hyst        = cfg_q.hyst;
  assign lim_upper       = lim_q[LIM_HI*LIM_W +: LIM_W];
  assign lim_lower       = lim_q[LIM_LO*LIM_W +: LIM_W];
  assign lim_crit        = lim_q[LIM_CRIT*LIM_W +: LIM_W];

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_valid |=> $stable(temp_q)); // R6
endmodule

// File: tb/tsens_regbank_test.sv
module tsens_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_ptr_we, host_wr, host_rd;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        temp_valid;
  logic [12:0] temp_value;
  logic        temp_over_crit, temp_over_win, temp_under_win;
  logic        evt_status;
  logic [2:0]  strap;
  logic [6:0]  bus_addr;
  logic        addr_hit;
  logic        cfg_event_mode, cfg_active_high, cfg_crit_only, cfg_evt_enable, cfg_shutdown;
  logic [1:0]  cfg_hyst;
  logic        clr_event;
  logic [10:0] lim_upper, lim_lower, lim_crit;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;
  logic        mon_half = 1'b0;
  logic [7:0]  mon_msb = 8'h00;

  always #10 clk = ~clk;

  tsens_regbank uut (
    .clk(clk), .rst_n(rst_n), .host_ptr_we(host_ptr_we), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .temp_valid(temp_valid), .temp_value(temp_value), .temp_over_crit(temp_over_crit),
    .temp_over_win(temp_over_win), .temp_under_win(temp_under_win),
    .evt_status(evt_status), .strap(strap), .bus_addr(bus_addr), .addr_hit(addr_hit),
    .cfg_event_mode(cfg_event_mode), .cfg_active_high(cfg_active_high),
    .cfg_crit_only(cfg_crit_only), .cfg_evt_enable(cfg_evt_enable),
    .cfg_shutdown(cfg_shutdown), .cfg_hyst(cfg_hyst), .clr_event(clr_event),
    .lim_upper(lim_upper), .lim_lower(lim_lower), .lim_crit(lim_crit)
  );

  // monitor: assembles two read bytes and pops the scoreboard
  always @(posedge clk) rd_d <= host_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (!mon_half) begin
        mon_msb  = host_rdata;
        mon_half = 1'b1;
      end else begin
        logic [15:0] act, expv;
        string t;
        mon_half = 1'b0;
        act  = {mon_msb, host_rdata};
        expv = exp_q.pop_front();
        t    = tag_q.pop_front();
        compared++;
        if (act !== expv) begin
          mismatched++;
          $display("FAIL %s read actual=%h expected=%h", t, act, expv);
        end
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string t);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", t, act, expv);
    end
  endtask

  task automatic ptr_wr(input logic [7:0] p);
    @(negedge clk); host_ptr_we = 1'b1; host_wdata = p;
    @(negedge clk); host_ptr_we = 1'b0;
  endtask

  task automatic wr_word(input logic [15:0] w);
    @(negedge clk); host_wr = 1'b1; host_wdata = w[15:8];
    @(negedge clk); host_wdata = w[7:0];
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd_word(input logic [15:0] expv, input string t);
    exp_q.push_back(expv); tag_q.push_back(t);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk);
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic rd_one();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic load_sample(input logic [12:0] v, input logic c, input logic a, input logic b);
    @(negedge clk);
    temp_value = v; temp_over_crit = c; temp_over_win = a; temp_under_win = b; temp_valid = 1'b1;
    @(negedge clk); temp_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_ptr_we = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
    temp_valid = 0; temp_value = 0; temp_over_crit = 0; temp_over_win = 0; temp_under_win = 0;
    evt_status = 0; strap = 3'b000; bus_addr = 7'h18;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    ptr_wr(8'h00); rd_word(16'h0001, "R1 cap");
    ptr_wr(8'h01); rd_word(16'h0000, "R1 cfg");
    ptr_wr(8'h02); rd_word(16'h0000, "R1 upper");
    ptr_wr(8'h03); rd_word(16'h0000, "R1 lower");
    ptr_wr(8'h04); rd_word(16'h0000, "R1 crit");
    ptr_wr(8'h05); rd_word(16'h0000, "R1 sample");
    chk({5'b0, lim_upper}, 16'h0000, "R1 lim_upper");
    chk({15'b0, clr_event}, 16'h0000, "R1 clr_event");

    // R4 capability read-only
    ptr_wr(8'h00); wr_word(16'hFFFF); rd_word(16'h0001, "R4 cap write");

    // R5 limit storage and reserved bits
    ptr_wr(8'h02); wr_word(16'hFFFF); rd_word(16'h1FFC, "R5 upper ones");
    ptr_wr(8'h03); wr_word(16'h0A5F); rd_word(16'h0A5C, "R5 lower");
    ptr_wr(8'h04); wr_word(16'h0550); rd_word(16'h0550, "R5 crit");
    chk({5'b0, lim_upper}, 16'h07FF, "R5 lim_upper");
    chk({5'b0, lim_lower}, 16'h0297, "R5 lim_lower");
    chk({5'b0, lim_crit},  16'h0154, "R5 lim_crit");

    // R2 unmapped pointers
    ptr_wr(8'h06); rd_word(16'h0000, "R2 sel 110");
    ptr_wr(8'h0A); wr_word(16'h1234); rd_word(16'h0000, "R2 upper bits set");
    ptr_wr(8'h02); rd_word(16'h1FFC, "R2 write via bad pointer ignored");

    // R6 sample word
    load_sample(13'h0C91, 1'b1, 1'b0, 1'b1);
    ptr_wr(8'h05); rd_word(16'hAC91, "R6 sample");
    wr_word(16'hFFFF); rd_word(16'hAC91, "R6 host write ignored");

    // R3 read capture: sample changes between the two byte reads
    ptr_wr(8'h05);
    exp_q.push_back(16'hAC91); tag_q.push_back("R3 coherent word");
    rd_one();
    load_sample(13'h0123, 1'b0, 1'b0, 1'b0);
    rd_one();
    rd_word(16'h0123, "R6 new sample");

    // R3 half write then pointer restart
    ptr_wr(8'h03);
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'h00;
    @(negedge clk); host_wr = 1'b0;
    ptr_wr(8'h03); rd_word(16'h0A5C, "R3 single byte no effect");

    // R10 / R11 configuration all ones, no lock held before
    evt_status = 1'b1;
    ptr_wr(8'h01);
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'hFF;
    @(negedge clk); host_wdata = 8'hFF;
    chk({15'b0, clr_event}, 16'h0000, "R11 no pulse before second byte");
    @(negedge clk); host_wr = 1'b0;
    chk({15'b0, clr_event}, 16'h0001, "R11 pulse after write");
    @(negedge clk);
    chk({15'b0, clr_event}, 16'h0000, "R11 pulse one cycle");
    rd_word(16'h07DF, "R10 cfg ones with status");
    chk({10'b0, cfg_hyst, cfg_shutdown, cfg_evt_enable, cfg_active_high, cfg_event_mode},
        16'h003F, "R10 exported cfg fields");

    // R7 / R8 locks active
    ptr_wr(8'h02); wr_word(16'h0004); rd_word(16'h1FFC, "R7 upper locked");
    ptr_wr(8'h03); wr_word(16'h0000); rd_word(16'h0A5C, "R7 lower locked");
    ptr_wr(8'h04); wr_word(16'h0000); rd_word(16'h0550, "R8 crit locked");

    // R9 mode and polarity frozen while locked
    evt_status = 1'b0;
    ptr_wr(8'h01); wr_word(16'h0000); rd_word(16'h0003, "R9 mode/pol held");
    chk({15'b0, clr_event}, 16'h0000, "R11 no pulse when bit5 clear");
    wr_word(16'h0000); rd_word(16'h0000, "R9 unlocked clear");
    wr_word(16'h0040); rd_word(16'h0040, "R9 set alarm lock");
    wr_word(16'h0143); rd_word(16'h0140, "R9 other fields move");
    wr_word(16'h0000); rd_word(16'h0000, "R9 release");

    // R7 unlocked write works again
    ptr_wr(8'h02); wr_word(16'h0100); rd_word(16'h0100, "R7 upper unlocked");
    ptr_wr(8'h04); wr_word(16'h1FFC); rd_word(16'h1FFC, "R8 crit unlocked");

    // R12 address decode
    @(negedge clk);
    chk({15'b0, addr_hit}, 16'h0001, "R12 strap 000");
    strap = 3'b101; bus_addr = 7'h1D; @(negedge clk);
    chk({15'b0, addr_hit}, 16'h0001, "R12 strap 101");
    bus_addr = 7'h3D; @(negedge clk);
    chk({15'b0, addr_hit}, 16'h0000, "R12 prefix mismatch");
    bus_addr = 7'h18; @(negedge clk);
    chk({15'b0, addr_hit}, 16'h0000, "R12 strap mismatch");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R3 pending reads actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule